// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase Detector Core

This block is the digital heart of an integer-N frequency synthesizer loop. A reference divider counts crystal ticks to form the comparison stream, and a 15-bit programmable divider counts oscillator-derived ticks to form the divided stream. A tri-state phase/frequency detector compares the two streams and produces up and down commands for an external charge pump. The loop step therefore equals the comparison rate.

A lock monitor watches the widths of the detector pulses and raises a lock flag once the loop has stayed tight for a run of comparisons. A 3-bit mode word can force the pump to source, sink or idle, can release the tuning output, and can route the crystal, divided or comparison stream to a test pin. A 2-bit pump current code is passed through to the analog side. Both input streams arrive as one-cycle tick enables in the system clock domain. Ratio changes are picked up only at each divider's terminal count, and out-of-range settings are clamped and flagged.

Top module: `synthLoopCore`

## Requirements
- R1: The divided stream `divPulse` fires once every `divWord` ticks of `oscTick` for any `divWord` from 64 to 32767.
- R2: A `divWord` below 64 acts as 64 and sets `cfgError`.
- R3: For `refCode` 0 to 4 the comparison stream `compPulse` fires once every 2^(refCode+1) ticks of `xtalTick` (2, 4, 8, 16, 32).
- R4: A `refCode` of 5, 6 or 7 acts as a ratio of 32 and sets `cfgError`.
- R5: `cfgError` stays set until reset. Reset clears it, and it is 0 while all settings are legal.
- R6: A ratio change made during a divider period leaves that period at the old length. The next period uses the new ratio.
- R7: In normal mode (`modeCode` 000), a comparison pulse that leads the divided pulse by d cycles drives `cpUp` high for d+1 cycles and `cpDn` for 1 cycle. The mirror case swaps the two outputs.
- R8: `lockFlag` is 0 after reset. It rises only after 16 consecutive detector events whose one-sided pulse is no longer than 3 cycles.
- R9: Any detector event whose one-sided pulse exceeds 3 cycles clears `lockFlag`. A 3-cycle offset keeps lock; a 4-cycle offset prevents it.
- R10: Mode 010 forces sink (`cpDn`=1, `cpUp`=0). Mode 011 forces source (`cpUp`=1, `cpDn`=0). Mode 110 turns the pump off (`cpDrive`=0, both commands 0). Whenever `cpDrive` is 0, both commands are 0.
- R11: Mode 001 releases the tuning output (`tuneRelease`=1, `cpDrive`=0). Every other mode keeps `tuneRelease` at 0.
- R12: `testClk` follows `xtalTick` in mode 100, `divPulse` in mode 101 and `compPulse` in mode 111, and is 0 in every other mode.
- R13: `cpLevel` equals `cpCode` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| xtalTick | input | 1 | One-cycle tick per crystal period |
| oscTick | input | 1 | One-cycle tick per prescaled oscillator period |
| divWord | input | 15 | Main divider ratio |
| refCode | input | 3 | Reference ratio select |
| modeCode | input | 3 | Operating/test mode |
| cpCode | input | 2 | Charge-pump current select |
| cpUp | output | 1 | Pump source command |
| cpDn | output | 1 | Pump sink command |
| cpDrive | output | 1 | Pump output enabled |
| tuneRelease | output | 1 | Tuning output released (high impedance) |
| cpLevel | output | 2 | Pump current code to analog side |
| testClk | output | 1 | Selected internal stream for test |
| compPulse | output | 1 | Comparison stream pulse |
| divPulse | output | 1 | Divided stream pulse |
| lockFlag | output | 1 | Loop in-lock status |
| cfgError | output | 1 | Sticky illegal-setting flag |

## Verification
The bench builds the block with its defaults: a 15-bit divider with a floor of 64, five reference codes, a lock run of 16 and a window of 3 cycles. These sizes let the bench measure every legal reference ratio and the extreme divider values 64 and 32767 directly as pulse spacings. They also make lock reachable within about twenty 64-cycle comparison periods, so the window edge can be probed at 3 and 4 cycles of skew. Running both streams at the same 64-cycle period lets the bench set the phase offset exactly and predict the pulse widths.

// File: rtl/synthLoopPkg.sv
package synthLoopPkg;

  typedef enum logic [2:0] {
    MODE_NORMAL   = 3'b000,
    MODE_RELEASE  = 3'b001,
    MODE_SINK     = 3'b010,
    MODE_SOURCE   = 3'b011,
    MODE_XTAL_OUT = 3'b100,
    MODE_DIV_OUT  = 3'b101,
    MODE_CP_OFF   = 3'b110,
    MODE_COMP_OUT = 3'b111
  } loopMode_e;

  // Strobes and detector state handed from datapath to control
  typedef struct packed {
    logic compTick;
    logic divTick;
    logic upQ;
    logic dnQ;
  } pfdState_t;

endpackage

// File: rtl/synthDivider.sv
module synthDivider #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic [CW-1:0] reloadM1,
  output logic          pulse
);

  logic [CW-1:0] cnt;

  // Down counter; the reload value is sampled only at terminal count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (cnt == '0) begin
          cnt   <= reloadM1;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    pulse |=> !pulse); // R1 R3

endmodule

// File: rtl/synthDatapath.sv
module synthDatapath
  import synthLoopPkg::*;
#(
  parameter int NW  = 15,
  parameter int RCW = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           xtalTick,
  input  logic           oscTick,
  input  logic [RCW-1:0] refM1,
  input  logic [NW-1:0]  divM1,
  output pfdState_t      pfd
);

  logic compTick, divTick, upQ, dnQ;

  synthDivider #(.CW(RCW)) uRefDiv (
    .clk(clk), .rstN(rstN), .tick(xtalTick), .reloadM1(refM1), .pulse(compTick)
  );

  synthDivider #(.CW(NW)) uMainDiv (
    .clk(clk), .rstN(rstN), .tick(oscTick), .reloadM1(divM1), .pulse(divTick)
  );

  // Tri-state detector: edges set flops, coincidence clears them a cycle later
  always_ff @(posedge clk) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else if (upQ && dnQ) begin
      upQ <= compTick;
      dnQ <= divTick;
    end else begin
      upQ <= upQ | compTick;
      dnQ <= dnQ | divTick;
    end
  end

  assign pfd = '{compTick: compTick, divTick: divTick, upQ: upQ, dnQ: dnQ};

  AST_PFD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (upQ && dnQ) |=> !(upQ && dnQ)); // R7
  AST_UP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (upQ && !dnQ) |=> upQ); // R7
  AST_DN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (dnQ && !upQ) |=> dnQ); // R7

endmodule

// File: rtl/synthControl.sv
module synthControl
  import synthLoopPkg::*;
#(
  parameter int NW         = 15,
  parameter int RCW        = 5,
  parameter int REF_CODES  = 5,
  parameter int MIN_DIV    = 64,
  parameter int LOCK_COUNT = 16,
  parameter int LOCK_WIN   = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           xtalTick,
  input  logic [NW-1:0]  divWord,
  input  logic [2:0]     refCode,
  input  logic [2:0]     modeCode,
  input  logic [1:0]     cpCode,
  input  pfdState_t      pfd,
  output logic [RCW-1:0] refM1,
  output logic [NW-1:0]  divM1,
  output logic           cpUp,
  output logic           cpDn,
  output logic           cpDrive,
  output logic           tuneRelease,
  output logic [1:0]     cpLevel,
  output logic           testClk,
  output logic           lockFlag,
  output logic           cfgError
);

  localparam int EW = $clog2(LOCK_WIN + 1);
  localparam int GW = $clog2(LOCK_COUNT + 1);

  logic          refBad, divBad, errQ, wideSeen;
  logic [31:0]   refRatio;
  logic [EW-1:0] exclCnt;
  logic [GW-1:0] goodCnt;
  loopMode_e     mode;

  // Ratio clamping
  always_comb begin
    refBad   = (32'(refCode) >= REF_CODES);
    refRatio = 32'd2 << (refBad ? (REF_CODES - 1) : int'(refCode));
    refM1    = RCW'(refRatio - 32'd1);
    divBad   = (32'(divWord) < MIN_DIV);
    divM1    = divBad ? NW'(MIN_DIV - 1) : (divWord - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= errQ | refBad | divBad;
  end
  assign cfgError = errQ;

  // Mode decode
  always_comb begin
    mode        = loopMode_e'(modeCode);
    cpUp        = pfd.upQ;
    cpDn        = pfd.dnQ;
    cpDrive     = 1'b1;
    tuneRelease = 1'b0;
    testClk     = 1'b0;
    case (mode)
      MODE_RELEASE: begin
        cpUp = 1'b0; cpDn = 1'b0; cpDrive = 1'b0; tuneRelease = 1'b1;
      end
      MODE_SINK:     begin cpUp = 1'b0; cpDn = 1'b1; end
      MODE_SOURCE:   begin cpUp = 1'b1; cpDn = 1'b0; end
      MODE_CP_OFF:   begin cpUp = 1'b0; cpDn = 1'b0; cpDrive = 1'b0; end
      MODE_XTAL_OUT: testClk = xtalTick;
      MODE_DIV_OUT:  testClk = pfd.divTick;
      MODE_COMP_OUT: testClk = pfd.compTick;
      default:       ;
    endcase
  end
  assign cpLevel = cpCode;

  // Lock monitor: counts one-sided cycles per detector event
  always_ff @(posedge clk) begin
    if (!rstN) begin
      exclCnt  <= '0;
      goodCnt  <= '0;
      wideSeen <= 1'b0;
    end else if (pfd.upQ && pfd.dnQ) begin
      exclCnt  <= '0;
      wideSeen <= 1'b0;
      if (!wideSeen && goodCnt != GW'(LOCK_COUNT)) goodCnt <= goodCnt + 1'b1;
    end else if (pfd.upQ ^ pfd.dnQ) begin
      if (exclCnt == EW'(LOCK_WIN)) begin
        goodCnt  <= '0;
        wideSeen <= 1'b1;
      end else begin
        exclCnt <= exclCnt + 1'b1;
      end
    end
  end
  assign lockFlag = (goodCnt == GW'(LOCK_COUNT));

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cpDrive |-> (!cpUp && !cpDn)); // R10
  AST_BOTH_ONLY_CLOSING: assert property (@(posedge clk) disable iff (!rstN)
    (cpUp && cpDn) |-> (pfd.upQ && pfd.dnQ)); // R10
  AST_WIDE_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    ((pfd.upQ ^ pfd.dnQ) && exclCnt == EW'(LOCK_WIN)) |=> !lockFlag); // R9

endmodule

// File: rtl/synthLoopCore.sv
module synthLoopCore
  import synthLoopPkg::*;
#(
  parameter int NW         = 15,
  parameter int REF_CODES  = 5,
  parameter int MIN_DIV    = 64,
  parameter int LOCK_COUNT = 16,
  parameter int LOCK_WIN   = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          xtalTick,
  input  logic          oscTick,
  input  logic [NW-1:0] divWord,
  input  logic [2:0]    refCode,
  input  logic [2:0]    modeCode,
  input  logic [1:0]    cpCode,
  output logic          cpUp,
  output logic          cpDn,
  output logic          cpDrive,
  output logic          tuneRelease,
  output logic [1:0]    cpLevel,
  output logic          testClk,
  output logic          compPulse,
  output logic          divPulse,
  output logic          lockFlag,
  output logic          cfgError
);

  localparam int RCW = REF_CODES;

  pfdState_t      pfd;
  logic [RCW-1:0] refM1;
  logic [NW-1:0]  divM1;

  synthDatapath #(.NW(NW), .RCW(RCW)) uDatapath (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .oscTick(oscTick),
    .refM1(refM1), .divM1(divM1), .pfd(pfd)
  );

  synthControl #(
    .NW(NW), .RCW(RCW), .REF_CODES(REF_CODES), .MIN_DIV(MIN_DIV),
    .LOCK_COUNT(LOCK_COUNT), .LOCK_WIN(LOCK_WIN)
  ) uControl (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .divWord(divWord),
    .refCode(refCode), .modeCode(modeCode), .cpCode(cpCode), .pfd(pfd),
    .refM1(refM1), .divM1(divM1), .cpUp(cpUp), .cpDn(cpDn), .cpDrive(cpDrive),
    .tuneRelease(tuneRelease), .cpLevel(cpLevel), .testClk(testClk),
    .lockFlag(lockFlag), .cfgError(cfgError)
  );

  assign compPulse = pfd.compTick;
  assign divPulse  = pfd.divTick;

endmodule

// File: tb/tb_synthLoopCore.sv
module tb_synthLoopCore;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        xtalTick = 1'b0, oscTick = 1'b0;
  logic [14:0] divWord = 15'd64;
  logic [2:0]  refCode = 3'd4, modeCode = 3'd0;
  logic [1:0]  cpCode = 2'd0;
  logic        cpUp, cpDn, cpDrive, tuneRelease, testClk;
  logic        compPulse, divPulse, lockFlag, cfgError;
  logic [1:0]  cpLevel;

  synthLoopCore dut (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .oscTick(oscTick),
    .divWord(divWord), .refCode(refCode), .modeCode(modeCode), .cpCode(cpCode),
    .cpUp(cpUp), .cpDn(cpDn), .cpDrive(cpDrive), .tuneRelease(tuneRelease),
    .cpLevel(cpLevel), .testClk(testClk), .compPulse(compPulse),
    .divPulse(divPulse), .lockFlag(lockFlag), .cfgError(cfgError)
  );

  int checks = 0, errors = 0, stepCount = 0;
  bit xtalOn = 0, oscOn = 0, finished = 0;
  int xtalStride = 1, oscStride = 1, xPh = 0, oPh = 0;

  // Tick generator, updated away from the active edge
  initial forever begin
    @(negedge clk);
    xtalTick = xtalOn && (xPh == 0);
    oscTick  = oscOn && (oPh == 0);
    xPh = xtalOn ? (xPh + 1) % xtalStride : 0;
    oPh = oscOn ? (oPh + 1) % oscStride : 0;
  end

  task automatic step();
    @(posedge clk); #1; stepCount++;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitPulse(bit useDiv, output int at);
    at = -1;
    for (int i = 0; i < 70000; i++) begin
      step();
      if (useDiv ? divPulse : compPulse) begin at = stepCount; break; end
    end
  endtask

  task automatic doReset();
    xtalOn = 0; oscOn = 0; rstN = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    step();
  endtask

  // Both streams at 64 cycles; offset > 0 means comparison leads
  task automatic startLoop(int offset);
    refCode = 3'd4; divWord = 15'd64; modeCode = 3'd0;
    xtalStride = 2; oscStride = 1;
    doReset();
    if (offset >= 0) begin
      xtalOn = 1; repeat (offset) step(); oscOn = 1;
    end else begin
      oscOn = 1; repeat (-offset) step(); xtalOn = 1;
    end
  endtask

  // kind (0 = reference code, 1 = divider word), setting, expected spacing
  localparam int VEC [0:8][0:2] = '{
    '{0, 0, 2}, '{0, 1, 4}, '{0, 2, 8}, '{0, 3, 16}, '{0, 4, 32},
    '{1, 64, 64}, '{1, 200, 200}, '{1, 1000, 1000}, '{1, 32767, 32767}
  };

  initial begin
    #(8 * 190000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, b, c, upc, dnc, mism;

    // Reset state
    doReset();
    check("R8 reset lock", int'(lockFlag), 0);
    check("R5 reset error", int'(cfgError), 0);
    check("R7 reset up/dn", int'({cpUp, cpDn}), 0);
    check("R1 reset pulses", int'({compPulse, divPulse}), 0);

    // Ratio table
    xtalStride = 1; oscStride = 1; xtalOn = 1; oscOn = 1;
    for (int v = 0; v < 9; v++) begin
      if (VEC[v][0] == 0) refCode = 3'(VEC[v][1]);
      else                divWord = 15'(VEC[v][1]);
      waitPulse(VEC[v][0] == 1, a);
      waitPulse(VEC[v][0] == 1, b);
      check(VEC[v][0] == 0 ? "R3 ref spacing" : "R1 div spacing", b - a, VEC[v][2]);
    end
    check("R5 no error on legal", int'(cfgError), 0);

    // R6: change mid-period
    divWord = 15'd64;
    waitPulse(1, a); waitPulse(1, a);
    repeat (10) step();
    divWord = 15'd100;
    waitPulse(1, b); waitPulse(1, c);
    check("R6 old period kept", b - a, 64);
    check("R6 new period", c - b, 100);

    // R4 / R5 illegal reference code
    refCode = 3'd6;
    waitPulse(0, a); waitPulse(0, b);
    check("R4 clamp to 32", b - a, 32);
    check("R4 error set", int'(cfgError), 1);
    refCode = 3'd1;
    repeat (5) step();
    check("R5 sticky", int'(cfgError), 1);
    doReset();
    check("R5 cleared by reset", int'(cfgError), 0);

    // R2 small divider word
    xtalOn = 1; oscOn = 1; divWord = 15'd10;
    waitPulse(1, a); waitPulse(1, b);
    check("R2 clamp to 64", b - a, 64);
    check("R2 error set", int'(cfgError), 1);

    // R7 comparison leads by 5
    startLoop(5);
    repeat (3 * 64) step();
    upc = 0; dnc = 0;
    repeat (64) begin step(); upc += int'(cpUp); dnc += int'(cpDn); end
    check("R7 up width lead", upc, 6);
    check("R7 dn width lead", dnc, 1);
    check("R9 no lock at 5", int'(lockFlag), 0);

    // R7 divided leads by 5
    startLoop(-5);
    repeat (3 * 64) step();
    upc = 0; dnc = 0;
    repeat (64) begin step(); upc += int'(cpUp); dnc += int'(cpDn); end
    check("R7 dn width lag", dnc, 6);
    check("R7 up width lag", upc, 1);

    // R8 lock run length
    startLoop(0);
    repeat (10 * 64) step();
    check("R8 not yet locked", int'(lockFlag), 0);
    repeat (10 * 64) step();
    check("R8 locked", int'(lockFlag), 1);
    divWord = 15'd70;
    repeat (10 * 64) step();
    check("R9 lock lost on drift", int'(lockFlag), 0);

    // R9 window edge
    startLoop(3);
    repeat (20 * 64) step();
    check("R9 lock at offset 3", int'(lockFlag), 1);
    startLoop(4);
    repeat (20 * 64) step();
    check("R9 no lock at offset 4", int'(lockFlag), 0);

    // Modes
    modeCode = 3'b010; step();
    check("R10 sink", int'({cpUp, cpDn, cpDrive}), 3'b011);
    modeCode = 3'b011; step();
    check("R10 source", int'({cpUp, cpDn, cpDrive}), 3'b101);
    modeCode = 3'b110; step();
    check("R10 off", int'({cpUp, cpDn, cpDrive}), 3'b000);
    check("R11 off keeps tune", int'(tuneRelease), 0);
    modeCode = 3'b001; step();
    check("R11 release", int'({tuneRelease, cpDrive, cpUp, cpDn}), 4'b1000);
    modeCode = 3'b000; step();
    check("R11 normal", int'({tuneRelease, cpDrive}), 2'b01);

    modeCode = 3'b100; mism = 0;
    repeat (16) begin step(); if (testClk !== xtalTick) mism++; end
    check("R12 xtal on test pin", mism, 0);
    modeCode = 3'b000; mism = 0;
    repeat (16) begin step(); if (testClk !== 1'b0) mism++; end
    check("R12 quiet in normal", mism, 0);
    modeCode = 3'b101; mism = 0;
    repeat (130) begin step(); if (testClk !== divPulse) mism++; end
    check("R12 div on test pin", mism, 0);
    modeCode = 3'b111; mism = 0;
    repeat (130) begin step(); if (testClk !== compPulse) mism++; end
    check("R12 comp on test pin", mism, 0);

    cpCode = 2'd2; modeCode = 3'b001; step();
    check("R13 level pass", int'(cpLevel), 2);
    cpCode = 2'd3; modeCode = 3'b000; step();
    check("R13 level pass", int'(cpLevel), 3);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule